// File: doc/BRIEF.md
# Programmable Interval Timer Counter Channel

This block is a single channel of a six-mode interval timer. The channel counts ticks of a counting-clock enable since its most recent load, or since its most recent gate restart. It drives a single output level that is a pure function of that elapsed count, the loaded count and the mode.

The modes cover four behaviours: a level that rises at terminal count, a one-tick rate pulse every period, a square wave whose high phase is the longer one for odd counts, and a single-tick strobe. Software-side byte sequencing, latching and bus decoding live outside. The block receives a whole count and a mode through a one-cycle load strobe.

The gate input is registered every clock. Its registered level enables counting in the freezing modes. Its rising edge restarts counting in the retriggerable modes. The register's value out of reset is a per-instance parameter, so that channels whose gate is normally tied low start frozen.

Top module: `pit_channel`

## Requirements
- R1: Under reset the channel takes mode 3, an effective count of 65536 and an elapsed count of zero, so `out_lvl` is high right after reset is released.
- R2: A clock with `load_stb` high stores `load_mode` and `load_count` and sets the elapsed count to zero on that same clock. A `load_count` of 0 is stored as 65536.
- R3: In modes 0 and 1, `out_lvl` is low while the elapsed count is below the loaded count N. It is high from the point where the elapsed count reaches N, and stays high until the next load or restart.
- R4: In mode 2, `out_lvl` is high exactly when the elapsed count is a nonzero multiple of N, and low otherwise. With N = 1 it stays high after the first tick.
- R5: In mode 3, within each period of N ticks, `out_lvl` is high for the first ceil(N/2) ticks and low for the remaining ticks. An odd N therefore has a high phase one tick longer than the low phase, and N = 1 gives a constant high.
- R6: In modes 4 and 5, `out_lvl` is high only while the elapsed count equals N. After the next counted tick it stays low for good.
- R7: Mode codes 6 and 7 produce the same output as mode 0, including freezing on a low gate.
- R8: The elapsed count advances by one only on clocks where `tick_en` is high. With `tick_en` low the output does not change.
- R9: In modes 0, 2, 3, 4, 6 and 7, counting is enabled by the gate level registered on the previous clock. A low registered gate freezes the elapsed count and the output.
- R10: In modes 1 and 5, a clock where `gate_in` is high and the registered gate is low restarts counting from zero. The gate level does not otherwise stop counting in these modes.
- R11: The gate register resets to parameter `GATE_RST`. With `gate_in` low, a `GATE_RST` = 1 channel still counts the first tick after reset, while a `GATE_RST` = 0 channel does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| tick_en | input | 1 | Counting-clock enable, one tick per high cycle |
| load_stb | input | 1 | One-cycle strobe that loads mode and count |
| load_mode | input | 3 | Mode code 0 to 7 |
| load_count | input | CNT_W (16) | Initial count; 0 means 2^CNT_W |
| gate_in | input | 1 | Gate level |
| out_lvl | output | 1 | Channel output level |

## Verification
The bench builds two channels with the default 16-bit count. One has `GATE_RST` = 1 and the other has `GATE_RST` = 0, and both are driven by the same stimulus. The full-width count puts the 65536 reset count and the zero-means-full load on the real datapath width. A run through half of the reset square-wave period exposes the one-tick difference between the two gate reset values. Small odd and even counts, including 1, cover every mode's period edges, gate freezes, retriggers and tick gaps.

// File: rtl/pit_chan_pkg.sv
package pit_chan_pkg;

  // Output rule family selected by the 3-bit mode code
  typedef enum logic [1:0] {
    CLS_LEVEL  = 2'd0,  // modes 0, 1, 6, 7
    CLS_RATE   = 2'd1,  // mode 2
    CLS_SQUARE = 2'd2,  // mode 3
    CLS_STROBE = 2'd3   // modes 4, 5
  } pit_cls_e;

  function automatic pit_cls_e mode_class(input logic [2:0] m);
    pit_cls_e c;
    case (m)
      3'd2:       c = CLS_RATE;
      3'd3:       c = CLS_SQUARE;
      3'd4, 3'd5: c = CLS_STROBE;
      default:    c = CLS_LEVEL;
    endcase
    return c;
  endfunction

  // Modes whose gate edge restarts counting instead of gating it
  function automatic logic mode_retrig(input logic [2:0] m);
    return (m == 3'd1) || (m == 3'd5);
  endfunction

endpackage

// File: rtl/pit_ctl_reg.sv
module pit_ctl_reg
  import pit_chan_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter bit GATE_RST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_stb,
  input  logic [2:0]       load_mode,
  input  logic [CNT_W-1:0] load_count,
  input  logic             gate_in,
  output pit_cls_e         cls,
  output logic             retrig,
  output logic [CNT_W:0]   n_eff,
  output logic             gate_q,
  output logic             gate_rise
);
  localparam int EFF_W = CNT_W + 1;
  localparam logic [EFF_W-1:0] FULL_CNT = EFF_W'(1) << CNT_W;
  localparam logic [2:0] RST_MODE = 3'd3;

  logic [2:0]       mode_q, mode_d;
  logic [EFF_W-1:0] n_q, n_d;
  logic             gate_d;

  // Next state
  always_comb begin
    mode_d = mode_q;
    n_d    = n_q;
    gate_d = gate_in;
    if (load_stb) begin
      mode_d = load_mode;
      n_d    = (load_count == '0) ? FULL_CNT : {1'b0, load_count};
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RST_MODE;
      n_q    <= FULL_CNT;
      gate_q <= GATE_RST;
    end else begin
      mode_q <= mode_d;
      n_q    <= n_d;
      gate_q <= gate_d;
    end
  end

  assign cls       = mode_class(mode_q);
  assign retrig    = mode_retrig(mode_q);
  assign n_eff     = n_q;
  assign gate_rise = retrig & gate_in & ~gate_q;

  // R2: a zero count word is held as the full range
  a_r2_zero_is_full: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && load_count == '0) |=> (n_eff == FULL_CNT));

  // R2: the mode class after a load follows the loaded code
  a_r2_mode_capture: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> (cls == mode_class($past(load_mode))));

endmodule

// File: rtl/pit_elapsed.sv
module pit_elapsed
  import pit_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_stb,
  input  logic           tick_en,
  input  logic           gate_q,
  input  logic           gate_rise,
  input  logic           retrig,
  input  pit_cls_e       cls,
  input  logic [CNT_W:0] n_eff,
  output logic [CNT_W:0] el_q,
  output logic           started_q
);
  localparam int EFF_W = CNT_W + 1;

  logic [EFF_W-1:0] el_d;
  logic             started_d;
  logic             adv;
  logic             wrap_pt;

  // Retriggerable modes ignore the gate level; the rest need it high
  assign adv     = tick_en & (retrig | gate_q);
  assign wrap_pt = (el_q == n_eff - EFF_W'(1));

  always_comb begin
    el_d      = el_q;
    started_d = started_q;
    if (load_stb || gate_rise) begin
      el_d      = '0;
      started_d = 1'b0;
    end else if (adv) begin
      case (cls)
        CLS_RATE, CLS_SQUARE: begin
          // Phase within the period; no divider needed
          started_d = 1'b1;
          el_d      = wrap_pt ? '0 : el_q + EFF_W'(1);
        end
        CLS_STROBE: begin
          // Saturate one past terminal so the strobe cannot recur
          if (el_q <= n_eff) el_d = el_q + EFF_W'(1);
        end
        default: begin
          // Saturate at terminal; the level stays high
          if (el_q < n_eff) el_d = el_q + EFF_W'(1);
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      el_q      <= '0;
      started_q <= 1'b0;
    end else begin
      el_q      <= el_d;
      started_q <= started_d;
    end
  end

  // R2: load restarts the elapsed state on the same clock
  a_r2_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> (el_q == '0 && !started_q));

  // R8: without a tick nothing moves
  a_r8_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !load_stb && !gate_rise) |=> ($stable(el_q) && $stable(started_q)));

  // R9: low registered gate freezes the gated modes
  a_r9_gate_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!retrig && !gate_q && !load_stb) |=> ($stable(el_q) && $stable(started_q)));

  // R10: gate edge in retriggerable modes restarts counting
  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_rise && !load_stb) |=> (el_q == '0));

  // R5: periodic phase never reaches the count
  a_r5_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CLS_RATE || cls == CLS_SQUARE) |-> (el_q < n_eff));

endmodule

// File: rtl/pit_out_decode.sv
module pit_out_decode
  import pit_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  pit_cls_e       cls,
  input  logic [CNT_W:0] el_q,
  input  logic           started_q,
  input  logic [CNT_W:0] n_eff,
  output logic           out_lvl
);
  localparam int EFF_W = CNT_W + 1;

  logic [EFF_W:0] half_hi;

  // ceil(N/2) computed one bit wider so 2^CNT_W + 1 cannot overflow
  assign half_hi = ({1'b0, n_eff} + (EFF_W+1)'(1)) >> 1;

  always_comb begin
    case (cls)
      CLS_RATE:   out_lvl = started_q && (el_q == '0);
      CLS_SQUARE: out_lvl = ({1'b0, el_q} < half_hi);
      CLS_STROBE: out_lvl = (el_q == n_eff);
      default:    out_lvl = (el_q >= n_eff);
    endcase
  end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_chan_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter bit GATE_RST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             load_stb,
  input  logic [2:0]       load_mode,
  input  logic [CNT_W-1:0] load_count,
  input  logic             gate_in,
  output logic             out_lvl
);
  localparam int EFF_W = CNT_W + 1;

  pit_cls_e         cls;
  logic             retrig;
  logic [EFF_W-1:0] n_eff;
  logic             gate_q;
  logic             gate_rise;
  logic [EFF_W-1:0] el_q;
  logic             started_q;

  pit_ctl_reg #(.CNT_W(CNT_W), .GATE_RST(GATE_RST)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_stb   (load_stb),
    .load_mode  (load_mode),
    .load_count (load_count),
    .gate_in    (gate_in),
    .cls        (cls),
    .retrig     (retrig),
    .n_eff      (n_eff),
    .gate_q     (gate_q),
    .gate_rise  (gate_rise)
  );

  pit_elapsed #(.CNT_W(CNT_W)) u_elapsed (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_stb  (load_stb),
    .tick_en   (tick_en),
    .gate_q    (gate_q),
    .gate_rise (gate_rise),
    .retrig    (retrig),
    .cls       (cls),
    .n_eff     (n_eff),
    .el_q      (el_q),
    .started_q (started_q)
  );

  pit_out_decode #(.CNT_W(CNT_W)) u_dec (
    .cls       (cls),
    .el_q      (el_q),
    .started_q (started_q),
    .n_eff     (n_eff),
    .out_lvl   (out_lvl)
  );

  // R1: output high on the first clock after reset release
  a_r1_reset_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> out_lvl);

  // R3: the level rule never drops without a load or restart
  a_r3_level_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CLS_LEVEL && out_lvl && !load_stb && !gate_rise) |=> out_lvl);

  // R6: a strobe lasts exactly one counted tick
  a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CLS_STROBE && out_lvl && tick_en && (retrig || gate_q)
     && !load_stb && !gate_rise) |=> !out_lvl);

  // R4: rate pulse is one tick wide for counts above one
  a_r4_rate_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CLS_RATE && out_lvl && tick_en && gate_q && !load_stb
     && n_eff > EFF_W'(1)) |=> !out_lvl);

endmodule

// File: tb/pit_channel_tb_top.sv
`timescale 1ns/1ps
module pit_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en;
  logic        load_stb;
  logic [2:0]  load_mode;
  logic [15:0] load_count;
  logic        gate_in;
  logic        out_a;
  logic        out_b;

  int    checks = 0;
  int    fails  = 0;
  string req    = "R1";

  longint m_d[2];
  longint m_n[2];
  int     m_mode[2];
  bit     m_g[2];

  always #5 clk = ~clk;

  pit_channel #(.CNT_W(16), .GATE_RST(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load_stb(load_stb),
    .load_mode(load_mode), .load_count(load_count), .gate_in(gate_in),
    .out_lvl(out_a));

  pit_channel #(.CNT_W(16), .GATE_RST(1'b0)) dut_g0_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load_stb(load_stb),
    .load_mode(load_mode), .load_count(load_count), .gate_in(gate_in),
    .out_lvl(out_b));

  function automatic bit exp_out(int k);
    longint d = m_d[k];
    longint n = m_n[k];
    case (m_mode[k])
      2:       return (d != 0) && (d % n == 0);
      3:       return (d % n) < ((n + 1) / 2);
      4, 5:    return d == n;
      default: return d >= n;
    endcase
  endfunction

  task automatic check_bit(string r, bit got, bit exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s out=%0b expected=%0b t=%0t", r, got, exp, $time);
    end
  endtask

  task automatic compare();
    check_bit(req, out_a, exp_out(0));
    check_bit(req, out_b, exp_out(1));
  endtask

  task automatic model_clock();
    for (int k = 0; k < 2; k++) begin
      bit retr = (m_mode[k] == 1) || (m_mode[k] == 5);
      if (load_stb) begin
        m_mode[k] = int'(load_mode);
        m_n[k]    = (load_count == 16'd0) ? 65536 : longint'(load_count);
        m_d[k]    = 0;
      end else if (retr && gate_in && !m_g[k]) begin
        m_d[k] = 0;
      end else if (tick_en && (retr || m_g[k])) begin
        m_d[k]++;
      end
      m_g[k] = gate_in;
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    model_clock();
    compare();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic load(int mode, int cnt);
    load_mode  = 3'(mode);
    load_count = 16'(cnt);
    load_stb   = 1'b1;
    step();
    load_stb   = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int k = 0; k < 2; k++) begin
      m_mode[k] = 3;
      m_n[k]    = 65536;
      m_d[k]    = 0;
      m_g[k]    = (k == 0);
    end
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
    req = "R1";
    check_bit("R1 reset out A", out_a, 1'b1);
    check_bit("R1 reset out B", out_b, 1'b1);
  endtask

  initial begin
    #1_900_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    tick_en = 1'b1; load_stb = 1'b0; load_mode = '0; load_count = '0;
    gate_in = 1'b1; rst_n = 1'b0;

    // R1: reset defaults, full-count square wave stays high early on
    do_reset();
    req = "R1"; run(20);

    // R5: square wave, odd, even and count 1
    req = "R5"; load(3, 5); run(25);
    load(3, 4); run(20);
    load(3, 1); run(6);

    // R4: rate generator
    req = "R4"; load(2, 3); run(12);
    load(2, 1); run(6);
    load(2, 2); run(9);

    // R3: level modes
    req = "R3"; load(0, 4); run(10);
    load(1, 2); run(6);
    load(0, 1); run(4);

    // R6: strobe modes
    req = "R6"; load(4, 3); run(10);
    load(5, 2); run(8);
    load(4, 1); run(5);

    // R7: codes 6 and 7 act like mode 0, gate included
    req = "R7"; load(6, 3); run(6);
    load(7, 4); gate_in = 1'b0; run(3); gate_in = 1'b1; run(8);

    // R2: zero count means 65536; load restarts mid-count
    req = "R2"; load(0, 0); run(20);
    load(3, 0); run(10);
    load(3, 7); run(4); load(3, 7); run(10);

    // R8: gaps in the tick enable
    req = "R8"; load(3, 3);
    for (int i = 0; i < 18; i++) begin
      tick_en = (i % 3) != 1;
      step();
    end
    tick_en = 1'b0; load(0, 2); run(5);
    tick_en = 1'b1; run(4);

    // R9: low gate freezes gated modes
    req = "R9"; load(2, 4); run(3);
    gate_in = 1'b0; run(4); gate_in = 1'b1; run(8);
    load(3, 5); run(2); gate_in = 1'b0; run(5); gate_in = 1'b1; run(10);
    load(4, 3); gate_in = 1'b0; run(5); gate_in = 1'b1; run(6);

    // R10: gate edge restarts modes 1 and 5; low level does not stop them
    req = "R10"; load(1, 3); run(5);
    gate_in = 1'b0; run(2);
    gate_in = 1'b1; step();
    check_bit("R10 mode1 restart low", out_a, 1'b0);
    run(5);
    load(5, 3); run(2);
    gate_in = 1'b0; run(2);
    gate_in = 1'b1; run(6);
    gate_in = 1'b0; step(); gate_in = 1'b1; run(5);

    // R11: gate reset value; GATE_RST=1 counts first tick with gate low
    gate_in = 1'b0;
    do_reset();
    req = "R11";
    run(1);
    gate_in = 1'b1;
    run(32768);
    check_bit("R11 GATE_RST=1 reached half", out_a, 1'b0);
    check_bit("R11 GATE_RST=0 one behind", out_b, 1'b1);
    run(3);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule